// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry

This block takes a 32-bit register value and shapes it into the second operand of an arithmetic or logical operation. It applies one of five shift kinds: logical left, logical right, arithmetic right, rotate right, and rotate right by one through the carry. It also returns the carry-out of the shifter, which is the last bit moved out of the word. A kind of logical left with an amount of zero is the "no shift" case. In that case the value passes through unchanged and the incoming carry is returned as the carry-out.

The block is purely combinational. The caller supplies the value, a 3-bit kind code, a 6-bit amount and the current carry flag. It gets back the shaped word, the carry-out and a flag that marks an amount that the selected kind does not accept. The block does not decode instruction fields and does not write any flag register. The input value is only read. When the flag is raised, the output falls back to the unshifted value with the carry-in forwarded.

Kind codes: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, 4 = rotate right with extend. Codes 5 to 7 are unused.

Top module: `o2_shifter`

## Requirements
- R1: Kind 0 (logical left) accepts amounts 0 to 31. Amount n moves the word left by n places and fills with zeros. Amount 0 returns the value unchanged and returns carry_in as carry_out.
- R2: Kind 1 (logical right) accepts amounts 1 to 32 and fills with zeros. An amount of 32 gives a result of zero.
- R3: Kind 2 (arithmetic right) accepts amounts 1 to 32 and fills with copies of input bit 31. An amount of 32 gives a word of all copies of bit 31.
- R4: Kind 3 (rotate right) accepts amounts 1 to 31. Bits leaving bit 0 re-enter at bit 31.
- R5: Kind 4 (rotate right with extend) moves the word right by one place, puts carry_in into bit 31 and returns input bit 0 as carry_out.
- R6: For kinds 0 to 3 with a non-zero legal amount, carry_out is the last bit moved out. For left shifts by n this is input bit 32-n. For the right kinds it is input bit n-1, so an amount of 32 gives input bit 31.
- R7: An amount outside the legal range of the selected kind raises amt_illegal. result then equals operand_in and carry_out equals carry_in. For every legal amount, amt_illegal is low.
- R8: Kind codes 5, 6 and 7 always raise amt_illegal and pass the input through as in R7.
- R9: For kind 4 the amount input has no effect. Any amount gives the same result and carry_out, and amt_illegal stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_in | input | 32 | Register value to be shaped |
| shift_kind | input | 3 | Shift kind code (0 to 4 valid) |
| shift_amt | input | 6 | Shift amount |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shaped second operand |
| carry_out | output | 1 | Shifter carry-out |
| amt_illegal | output | 1 | Amount or kind not accepted |

## Verification
Every output is combinational, so result, carry_out and amt_illegal are due in the same cycle as the inputs that produce them, with zero register delay. The bench drives a new input set just after a rising edge and compares all three outputs at the following falling edge. By then the logic has settled and no edge ordering is involved. For each kind code and every amount from 0 to 63, several random words and carry values are applied. These are mixed with directed words that stress the fill and carry bits, and every comparison is made against a model that shifts one bit at a time.

// File: rtl/o2_pkg.sv
package o2_pkg;

    // Shift kind encoding seen at the top-level port
    typedef enum logic [2:0] {
        KIND_LSL = 3'd0,
        KIND_LSR = 3'd1,
        KIND_ASR = 3'd2,
        KIND_ROR = 3'd3,
        KIND_RRX = 3'd4
    } shift_kind_e;

endpackage

// File: rtl/o2_range_check.sv
// Decides whether the amount is accepted by the selected kind.
module o2_range_check
    import o2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic [2:0]       kind,
    input  logic [AMT_W-1:0] amt,
    output logic             illegal
);
    localparam logic [AMT_W:0] AMT_FULL = (AMT_W+1)'(DATA_W);

    logic [AMT_W:0] amt_ext;
    logic           amt_zero;

    assign amt_ext  = {1'b0, amt};
    assign amt_zero = (amt == '0);

    always_comb begin
        unique case (kind)
            KIND_LSL: illegal = (amt_ext >= AMT_FULL);
            KIND_LSR,
            KIND_ASR: illegal = amt_zero || (amt_ext > AMT_FULL);
            KIND_ROR: illegal = amt_zero || (amt_ext >= AMT_FULL);
            KIND_RRX: illegal = 1'b0;
            default:  illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/o2_barrel_right.sv
// Logarithmic right shifter: zero fill, constant fill or rotate.
module o2_barrel_right #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  logic              rotate,
    input  logic              fill,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [0:AMT_W];

    assign stage[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        if (STEP < DATA_W) begin : g_part
            logic [DATA_W-1:0] moved;
            always_comb begin
                if (rotate)
                    moved = {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]};
                else
                    moved = {{STEP{fill}}, stage[k][DATA_W-1:STEP]};
            end
            assign stage[k+1] = amt[k] ? moved : stage[k];
        end else begin : g_full
            // Step covers the whole word: only fill bits remain
            assign stage[k+1] = amt[k] ? {DATA_W{fill}} : stage[k];
        end
    end

    assign dout = stage[AMT_W];
endmodule

// File: rtl/o2_carry_pick.sv
// Selects the last bit moved out of a right shift: din[amt-1].
module o2_carry_pick #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    output logic              bit_out
);
    localparam int             IDX_W    = $clog2(DATA_W);
    localparam logic [AMT_W:0] AMT_FULL = (AMT_W+1)'(DATA_W);

    logic [AMT_W-1:0] amt_m1;
    logic [IDX_W-1:0] idx;
    logic             in_range;

    assign amt_m1   = amt - 1'b1;
    assign idx      = amt_m1[IDX_W-1:0];
    assign in_range = (amt != '0) && ({1'b0, amt} <= AMT_FULL);
    assign bit_out  = in_range ? din[idx] : 1'b0;
endmodule

// File: rtl/o2_shifter.sv
// Second-operand shifter: top level.
module o2_shifter
    import o2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] operand_in,
    input  logic [2:0]        shift_kind,
    input  logic [AMT_W-1:0]  shift_amt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              amt_illegal
);
    shift_kind_e       kind;
    logic              illegal;
    logic              left;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] core_in;
    logic [DATA_W-1:0] core_out;
    logic [DATA_W-1:0] core_out_rev;
    logic              picked;

    assign kind = shift_kind_e'(shift_kind);
    assign left = (kind == KIND_LSL);

    // A left shift is done as a right shift of the bit-reversed word
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_in[i]       = operand_in[DATA_W-1-i];
        assign core_out_rev[i] = core_out[DATA_W-1-i];
    end

    assign core_in = left ? rev_in : operand_in;

    o2_range_check #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_range (
        .kind    (shift_kind),
        .amt     (shift_amt),
        .illegal (illegal)
    );

    o2_barrel_right #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
        .din    (core_in),
        .amt    (shift_amt),
        .rotate (kind == KIND_ROR),
        .fill   ((kind == KIND_ASR) & operand_in[DATA_W-1]),
        .dout   (core_out)
    );

    o2_carry_pick #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_carry (
        .din     (core_in),
        .amt     (shift_amt),
        .bit_out (picked)
    );

    always_comb begin
        amt_illegal = illegal;
        result      = operand_in;
        carry_out   = carry_in;
        if (!illegal) begin
            unique case (kind)
                KIND_LSL: begin
                    if (shift_amt != '0) begin
                        result    = core_out_rev;
                        carry_out = picked;
                    end
                end
                KIND_LSR, KIND_ASR, KIND_ROR: begin
                    result    = core_out;
                    carry_out = picked;
                end
                KIND_RRX: begin
                    result    = {carry_in, operand_in[DATA_W-1:1]};
                    carry_out = operand_in[0];
                end
                default: begin
                    result    = operand_in;
                    carry_out = carry_in;
                end
            endcase
        end
    end
endmodule

// File: rtl/o2_shifter_props.sv
// Checker bound to o2_shifter: relations between its ports.
module o2_shifter_props #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input logic [DATA_W-1:0] operand_in,
    input logic [2:0]        shift_kind,
    input logic [AMT_W-1:0]  shift_amt,
    input logic              carry_in,
    input logic [DATA_W-1:0] result,
    input logic              carry_out,
    input logic              amt_illegal
);
    logic known;
    assign known = !$isunknown({operand_in, shift_kind, shift_amt, carry_in,
                                result, carry_out, amt_illegal});

    always_comb begin
        if (known) begin
            if (amt_illegal) begin
                assert_illegal_passthru_R7:
                    assert (result == operand_in && carry_out == carry_in);
            end
            if (shift_kind > 3'd4) begin
                assert_unused_kind_R8: assert (amt_illegal);
            end
            if (shift_kind == 3'd0 && shift_amt == '0) begin
                assert_lsl_zero_R1:
                    assert (!amt_illegal && result == operand_in && carry_out == carry_in);
            end
            if (shift_kind == 3'd0 && shift_amt != '0 && !amt_illegal) begin
                assert_lsl_low_zero_R1: assert (result[0] == 1'b0);
            end
            if (shift_kind == 3'd1 && !amt_illegal) begin
                assert_lsr_top_zero_R2: assert (result[DATA_W-1] == 1'b0);
            end
            if (shift_kind == 3'd2 && !amt_illegal) begin
                assert_asr_sign_R3: assert (result[DATA_W-1] == operand_in[DATA_W-1]);
            end
            if (shift_kind == 3'd3 && !amt_illegal) begin
                assert_ror_ones_R4: assert ($countones(result) == $countones(operand_in));
                assert_ror_carry_R6: assert (carry_out == result[DATA_W-1]);
            end
            if (shift_kind == 3'd4) begin
                assert_rrx_shape_R5:
                    assert (result[DATA_W-1] == carry_in && carry_out == operand_in[0]);
                assert_rrx_legal_R9: assert (!amt_illegal);
            end
        end
    end
endmodule

bind o2_shifter o2_shifter_props #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_props (
    .operand_in  (operand_in),
    .shift_kind  (shift_kind),
    .shift_amt   (shift_amt),
    .carry_in    (carry_in),
    .result      (result),
    .carry_out   (carry_out),
    .amt_illegal (amt_illegal)
);

// File: tb/o2_shifter_test.sv
module o2_shifter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] operand_in;
    logic [2:0]  shift_kind;
    logic [5:0]  shift_amt;
    logic        carry_in;
    logic [31:0] result;
    logic        carry_out;
    logic        amt_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    o2_shifter uut (
        .operand_in  (operand_in),
        .shift_kind  (shift_kind),
        .shift_amt   (shift_amt),
        .carry_in    (carry_in),
        .result      (result),
        .carry_out   (carry_out),
        .amt_illegal (amt_illegal)
    );

    // Reference: legality from the requirements
    function automatic bit ref_illegal(input logic [2:0] k, input int n);
        case (k)
            3'd0:    return n > 31;          // R1
            3'd1:    return n < 1 || n > 32; // R2
            3'd2:    return n < 1 || n > 32; // R3
            3'd3:    return n < 1 || n > 31; // R4
            3'd4:    return 1'b0;            // R9
            default: return 1'b1;            // R8
        endcase
    endfunction

    // Reference: one bit per step; the carry is the last bit moved out
    function automatic logic [32:0] ref_shift(input logic [2:0] k, input int n,
                                              input logic [31:0] d, input logic c);
        logic [31:0] r;
        logic        co;
        r  = d;
        co = c;
        if (ref_illegal(k, n)) return {co, r};
        case (k)
            3'd0: for (int i = 0; i < n; i++) begin co = r[31]; r = {r[30:0], 1'b0}; end
            3'd1: for (int i = 0; i < n; i++) begin co = r[0];  r = {1'b0, r[31:1]}; end
            3'd2: for (int i = 0; i < n; i++) begin co = r[0];  r = {d[31], r[31:1]}; end
            3'd3: for (int i = 0; i < n; i++) begin co = r[0];  r = {r[0], r[31:1]}; end
            default: begin co = d[0]; r = {c, d[31:1]}; end
        endcase
        return {co, r};
    endfunction

    function automatic string tag_of(input logic [2:0] k, input int n);
        if (k > 3'd4) return "R8";
        if (ref_illegal(k, n)) return "R7";
        case (k)
            3'd0:    return (n == 0) ? "R1" : "R1/R6";
            3'd1:    return "R2/R6";
            3'd2:    return "R3/R6";
            3'd3:    return "R4/R6";
            default: return "R5/R9";
        endcase
    endfunction

    task automatic apply(input logic [2:0] k, input int n, input logic [31:0] d,
                         input logic c, input string tag);
        logic [32:0] exp;
        bit          exp_ill;
        @(posedge clk);
        #1;
        shift_kind = k;
        shift_amt  = 6'(n);
        operand_in = d;
        carry_in   = c;
        exp     = ref_shift(k, n, d, c);
        exp_ill = ref_illegal(k, n);
        @(negedge clk);
        checks++;
        if (result !== exp[31:0] || carry_out !== exp[32] || amt_illegal !== exp_ill) begin
            fails++;
            $display("FAIL %s kind=%0d amt=%0d in=%h cin=%b: got res=%h co=%b ill=%b, expected res=%h co=%b ill=%b",
                     tag, k, n, d, c, result, carry_out, amt_illegal,
                     exp[31:0], exp[32], exp_ill);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] corners [6];
        void'($urandom(32'd20240611));
        corners[0] = 32'h0000_0000;
        corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h8000_0000;
        corners[3] = 32'h0000_0001;
        corners[4] = 32'hA5A5_5A5A;
        corners[5] = 32'h7FFF_FFFE;

        // Idle state: all-zero inputs give zero output and no flag (R1)
        apply(3'd0, 0, 32'h0, 1'b0, "R1");

        // Directed corner cases
        apply(3'd1, 32, 32'h8000_0001, 1'b0, "R2/R6");
        apply(3'd2, 32, 32'h8000_0000, 1'b0, "R3/R6");
        apply(3'd2, 32, 32'h7FFF_FFFF, 1'b1, "R3/R6");
        apply(3'd0, 31, 32'h0000_0003, 1'b0, "R1/R6");
        apply(3'd3, 31, 32'h0000_0001, 1'b0, "R4/R6");
        apply(3'd4, 0,  32'h0000_0001, 1'b1, "R5");
        apply(3'd4, 63, 32'h0000_0001, 1'b0, "R9");
        apply(3'd3, 0,  32'h1234_5678, 1'b1, "R7");
        apply(3'd3, 32, 32'h1234_5678, 1'b0, "R7");
        apply(3'd1, 33, 32'hFFFF_FFFF, 1'b1, "R7");
        apply(3'd7, 4,  32'hDEAD_BEEF, 1'b0, "R8");

        // Sweep every kind and amount with corner and random words
        for (int k = 0; k < 8; k++) begin
            for (int n = 0; n < 64; n++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [31:0] d;
                    logic        c;
                    d = (j < 2) ? corners[(n + j + k) % 6] : $urandom;
                    c = 1'($urandom);
                    apply(3'(k), n, d, c, tag_of(3'(k), n));
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule